// File: doc/BRIEF.md
# Ternary Spacer-Coded Link Transmitter

This block turns a one-bit binary stream into a return-to-spacer ternary symbol stream, so that the receiver can find each datum without a separate request wire. Every bit period has two halves. The first half carries the datum as a false or true symbol. The second half always carries the middle, or spacer, level. A receiver detects a new datum as a change from spacer to false or true. Because every datum is followed by a spacer, only half of the wire's symbol rate carries data.

The block runs from one clock at twice the bit rate. An internal phase register splits each bit period into a data slot and a spacer slot. The `bitStrobe` output is high in the cycle whose closing edge samples `dataIn` and `txEn`, so the source can present one new bit per strobe. The transmit enable is only read at the start of a bit, so switching it on or off never produces a partial symbol. While transmission is off, the line rests at the spacer level, and the first datum sent after an idle time is recognised by the same spacer-to-data change.

Each ternary symbol leaves the block as a 2-bit code. Analog level generation and the line driver sit outside the block.

Top module: `ternary_tx_link`

## Requirements
- R1: While `rstN` is low, `symOut` is the spacer code 2'b00 and `bitStrobe` is 1.
- R2: The symbol codes are: spacer 2'b00, false 2'b01, true 2'b10. The code 2'b11 never appears on `symOut`.
- R3: At a rising edge where `bitStrobe` is 1 and `txEn` is 1, the code for the sampled `dataIn` is registered. `dataIn` 0 gives false (2'b01) and `dataIn` 1 gives true (2'b10). The symbol is present on `symOut` for the following clock cycle.
- R4: At every rising edge where `bitStrobe` is 0, `symOut` becomes spacer. Every data symbol is therefore followed by exactly one spacer cycle.
- R5: At a rising edge where `bitStrobe` is 1 and `txEn` is 0, `symOut` becomes spacer. While the block is disabled, the line stays at spacer continuously.
- R6: `txEn` and `dataIn` are ignored at edges where `bitStrobe` is 0. Raising or dropping them in the spacer slot never shortens or inserts a data symbol.
- R7: `bitStrobe` alternates every clock cycle. It is 1 in the first cycle after reset is released.
- R8: With transmission enabled, the input bits 0,1,0,1 produce the symbol sequence false, spacer, true, spacer, false, spacer, true, spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Transmit enable, read at bit boundaries |
| dataIn | input | 1 | Binary data bit, read at bit boundaries |
| symOut | output | 2 | Ternary symbol code (00 spacer, 01 false, 10 true) |
| bitStrobe | output | 1 | High in the cycle whose closing edge samples `txEn` and `dataIn` |

## Verification
The checker watches the following on every cycle:
- the illegal code never appears;
- the strobe alternates;
- every spacer-slot edge yields a spacer;
- every boundary edge yields either the encoded bit or an idle spacer, as selected by the enable;
- the output holds spacer during reset.

Some behaviour can only be shown by the bench's scenarios:
- the exact order of symbols for an alternating bit pattern;
- a clean start and stop of transmission;
- the enable and data being ignored when they are toggled during the spacer slot;
- reset asserted in the middle of a data symbol.

// File: rtl/tern_tx_pkg.sv
package tern_tx_pkg;
  localparam int SYM_W = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_SPC = 2'b00,
    SYM_F   = 2'b01,
    SYM_T   = 2'b10
  } symT;

  typedef struct packed {
    logic loadBit;
    logic spacerSlot;
  } txStrobeT;
endpackage

// File: rtl/tern_tx_ctrl.sv
module tern_tx_ctrl
  import tern_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEn,
  output txStrobeT strobe,
  output logic     bitStrobe
);
  // phaseQ = 0: the coming edge closes the bit boundary (data slot follows)
  logic phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= 1'b0;
    else       phaseQ <= ~phaseQ;
  end

  always_comb begin
    bitStrobe         = ~phaseQ;
    strobe.loadBit    = ~phaseQ & txEn;
    strobe.spacerSlot = phaseQ;
  end
endmodule

// File: rtl/tern_tx_dp.sv
module tern_tx_dp
  import tern_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  txStrobeT strobe,
  input  logic     dataIn,
  output symT      symQ
);
  symT symNext;

  always_comb begin
    symNext = SYM_SPC;
    if (strobe.loadBit)    symNext = dataIn ? SYM_T : SYM_F;
    if (strobe.spacerSlot) symNext = SYM_SPC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) symQ <= SYM_SPC;
    else       symQ <= symNext;
  end
endmodule

// File: rtl/ternary_tx_link.sv
module ternary_tx_link
  import tern_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             dataIn,
  output logic [SYM_W-1:0] symOut,
  output logic             bitStrobe
);
  txStrobeT strobe;
  symT      symQ;

  tern_tx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEn      (txEn),
    .strobe    (strobe),
    .bitStrobe (bitStrobe)
  );

  tern_tx_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dataIn (dataIn),
    .symQ   (symQ)
  );

  assign symOut = symQ;
endmodule

// File: rtl/ternary_tx_link_chk.sv
module ternary_tx_link_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txEn,
  input logic       dataIn,
  input logic [1:0] symOut,
  input logic       bitStrobe
);
  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    symOut != 2'b11); // R2

  AST_STROBE_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe); // R7

  AST_STROBE_RISES: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> bitStrobe); // R7

  AST_DATA_SYMBOL: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && txEn) |=> symOut == ($past(dataIn) ? 2'b10 : 2'b01)); // R3

  AST_IDLE_SPACER: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !txEn) |=> symOut == 2'b00); // R5

  AST_SPACER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> symOut == 2'b00); // R4

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_SPACER: assert (symOut == 2'b00 && bitStrobe); // R1
    end
  end
endmodule

bind ternary_tx_link ternary_tx_link_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txEn      (txEn),
  .dataIn    (dataIn),
  .symOut    (symOut),
  .bitStrobe (bitStrobe)
);

// File: tb/ternary_tx_link_tb.sv
module ternary_tx_link_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       dataIn = 1'b0;
  logic [1:0] symOut;
  logic       bitStrobe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ternary_tx_link u_dut (
    .clk(clk), .rstN(rstN), .txEn(txEn), .dataIn(dataIn),
    .symOut(symOut), .bitStrobe(bitStrobe)
  );

  // vector: {txEn, dataIn, expected data-slot code}
  localparam int NVEC = 14;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0_0_00, 4'b0_1_00,              // idle (R5)
    4'b1_0_01, 4'b1_1_10, 4'b1_0_01, 4'b1_1_10, // alternating (R8)
    4'b1_1_10, 4'b1_1_10, 4'b1_0_01, 4'b1_0_01, // runs (R3)
    4'b0_1_00, 4'b0_0_00,              // stop clean (R5)
    4'b1_1_10, 4'b0_1_00               // restart then stop
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a negedge where bitStrobe is 1
  task automatic sendBit(input logic en, input logic d, input logic [1:0] exp, input string req);
    txEn = en; dataIn = d;
    check("R7 strobe at boundary", {1'b0, bitStrobe}, 2'b01);
    @(negedge clk);
    check(req, symOut, exp);
    check("R2 no illegal code", {1'b0, symOut == 2'b11}, 2'b00);
    txEn = ~en; dataIn = ~d; // R6: toggled in spacer slot, must be ignored
    check("R7 strobe in spacer slot", {1'b0, bitStrobe}, 2'b00);
    @(negedge clk);
    check("R4/R6 spacer after symbol", symOut, 2'b00);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset symbol", symOut, 2'b00);
    check("R1 reset strobe", {1'b0, bitStrobe}, 2'b01);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      sendBit(VEC[i][3], VEC[i][2], VEC[i][1:0],
              VEC[i][3] ? "R3/R8 data symbol" : "R5 idle spacer");
    end
    // R6: enable only high during spacer slots over several bits
    for (int i = 0; i < 4; i++) begin
      txEn = 1'b0; dataIn = 1'b1;
      @(negedge clk);
      check("R6 enable outside boundary ignored", symOut, 2'b00);
      txEn = 1'b1;
      @(negedge clk);
      check("R6 enable outside boundary ignored", symOut, 2'b00);
    end
    txEn = 1'b0;
    // R1: asynchronous reset in the middle of a true symbol
    txEn = 1'b1; dataIn = 1'b1;
    @(negedge clk);
    check("R3 true before reset", symOut, 2'b10);
    #1 rstN = 1'b0;
    #1 check("R1 reset clears symbol", symOut, 2'b00);
    check("R1 reset strobe", {1'b0, bitStrobe}, 2'b01);
    @(negedge clk);
    rstN = 1'b1;
    txEn = 1'b1; dataIn = 1'b0;
    check("R7 first cycle after reset", {1'b0, bitStrobe}, 2'b01);
    @(negedge clk);
    check("R3 false after reset", symOut, 2'b01);
    txEn = 1'b0;
    @(negedge clk);
    check("R4 spacer after reset", symOut, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule